// File: doc/BRIEF.md
# Half-Word Write-Masked Control Register Pair

This block holds two 16-bit control registers behind a simple single-cycle register bus. Every 32-bit write word carries its own per-bit enable in its upper half: a stored bit changes only when the matching enable bit is set. Software can therefore change one field without first reading the register back. The enable half is never stored, and a read returns zero in the upper half of the data word.

The configuration register packs a PHY-internal address field, a data field and a strobe bit. Software issues a PHY configuration access in three writes. The first loads the address and data. The second sets the strobe. The third clears it again. On each 0-to-1 change of the stored strobe, the block emits a one-cycle transaction pulse on its PHY configuration port. The pulse carries the address and data that were stored at that moment. The lane register holds one idle control per lane, and each of these drives a lane idle output directly.

Top module: `hwmask_ctrl_regs`

## Requirements
- R1: A bus write to a mapped register updates stored bit x (0..15) with write bit x only when write bit x+16 is 1; every other stored bit keeps its value.
- R2: A read returns the addressed register's stored 16 bits in bits 15:0 and zero in bits 31:16, and it reflects a write from the cycle after that write.
- R3: After synchronous active-high reset, both registers read zero, and phy_cfg_valid, phy_cfg_addr, phy_cfg_data and lane_idle are all zero.
- R4: The configuration register holds the PHY address in bits 6:1 and the PHY data in bits 10:7. A transaction presents the values held in those fields at the strobe's rising edge, and phy_cfg_addr and phy_cfg_data then hold those values until the next transaction.
- R5: When stored configuration bit 0 (the strobe) changes from 0 to 1 on a write at clock edge k, phy_cfg_valid is high for exactly the one cycle that follows edge k+1.
- R6: No pulse is produced when the strobe is written 1 while already 1, is cleared, or is written with its enable bit 16 at 0.
- R7: lane_idle[n] equals stored lane-register bit 3+n, where 1 means idle and 0 means active.
- R8: With bus_wen low, or when the address matches neither register, no stored bit changes. A read of an unmapped address returns zero.
- R9: A write to one register leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address (configuration at CFG_OFS, lanes at LANE_OFS) |
| bus_wdata | input | 32 | Write word: value in 15:0, per-bit enable in 31:16 |
| bus_wen | input | 1 | Write enable, one write per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| phy_cfg_valid | output | 1 | One-cycle PHY configuration transaction pulse |
| phy_cfg_addr | output | PA_W | PHY-internal address of the last transaction |
| phy_cfg_data | output | PD_W | PHY data of the last transaction |
| lane_idle | output | LANES | Per-lane idle control, 1 = idle |

## Verification
A wrong bit in either stored register becomes visible on the next read of that register, which is combinational, in the same cycle. A wrong lane bit is also visible at once on lane_idle. A corrupted strobe or edge-detect state shows up as a pulse that is missing or appears twice in the cycle after the following edge. A capture error shows as the wrong phy_cfg_addr or phy_cfg_data in that same pulse cycle, and the wrong value then stays on those outputs until the next transaction. The bench therefore follows every write with a read of both registers and a check of the PHY and lane outputs two edges later, so that any such fault is caught within two cycles of the write that caused it.

// File: rtl/hwm_pkg.sv
package hwm_pkg;
   localparam int HALF_W = 16;
   localparam int WORD_W = 2 * HALF_W;

   typedef logic [HALF_W-1:0] half_t;
   typedef logic [WORD_W-1:0] word_t;

   // register decode result
   typedef enum logic [1:0] {
      RSEL_NONE = 2'd0,
      RSEL_CFG  = 2'd1,
      RSEL_LANE = 2'd2
   } rsel_e;
endpackage

// File: rtl/hwm_masked_half.sv
// Bit-wise write-enabled storage: each bit has its own enable from the mask half.
module hwm_masked_half #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         we,
   input  logic [W-1:0] val,
   input  logic [W-1:0] msk,
   output logic [W-1:0] q
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            bit_q <= 1'b0;
         end else if (we && msk[b]) begin
            bit_q <= val[b];
         end
      end
      assign q[b] = bit_q;
   end
endmodule

// File: rtl/hwm_cfg_port.sv
// Rising-edge detector on the stored strobe, capturing the fields at that edge.
module hwm_cfg_port #(
   parameter int PA_W = 6,
   parameter int PD_W = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            strb_q,
   input  logic [PA_W-1:0] fld_addr,
   input  logic [PD_W-1:0] fld_data,
   output logic            txn_valid,
   output logic [PA_W-1:0] txn_addr,
   output logic [PD_W-1:0] txn_data
);
   logic strb_d;
   logic rise;

   assign rise = strb_q & ~strb_d;

   always_ff @(posedge clk) begin
      if (rst) begin
         strb_d    <= 1'b0;
         txn_valid <= 1'b0;
         txn_addr  <= '0;
         txn_data  <= '0;
      end else begin
         strb_d    <= strb_q;
         txn_valid <= rise;
         if (rise) begin
            txn_addr <= fld_addr;
            txn_data <= fld_data;
         end
      end
   end
endmodule

// File: rtl/hwm_lane_idle.sv
// Maps stored idle bits onto per-lane outputs.
module hwm_lane_idle #(
   parameter int LANES = 4
) (
   input  logic [LANES-1:0] idle_bits,
   output logic [LANES-1:0] lane_idle
);
   for (genvar n = 0; n < LANES; n++) begin : g_lane
      assign lane_idle[n] = idle_bits[n];
   end
endmodule

// File: rtl/hwmask_ctrl_regs.sv
module hwmask_ctrl_regs
   import hwm_pkg::*;
#(
   parameter int ADDR_W   = 8,
   parameter int CFG_OFS  = 0,
   parameter int LANE_OFS = 4,
   parameter int LANES    = 4,
   parameter int STRB_BIT = 0,
   parameter int PA_LSB   = 1,
   parameter int PA_W     = 6,
   parameter int PD_LSB   = 7,
   parameter int PD_W     = 4,
   parameter int IDLE_LSB = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_wen,
   output logic [31:0]       bus_rdata,
   output logic              phy_cfg_valid,
   output logic [PA_W-1:0]   phy_cfg_addr,
   output logic [PD_W-1:0]   phy_cfg_data,
   output logic [LANES-1:0]  lane_idle
);
   localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_OFS);
   localparam logic [ADDR_W-1:0] LANE_A = ADDR_W'(LANE_OFS);
   localparam int PA_MSB = PA_LSB + PA_W - 1;
   localparam int PD_MSB = PD_LSB + PD_W - 1;

   // elaboration-time parameter checks
   if (WORD_W != 32) begin : g_err_word
      $error("bus word must be 32 bits");
   end
   if (LANES < 1 || LANES > 4) begin : g_err_lanes
      $error("LANES must be 1..4");
   end
   if (IDLE_LSB + LANES > HALF_W) begin : g_err_idle
      $error("lane idle field exceeds register");
   end
   if (PA_MSB >= HALF_W || PD_MSB >= HALF_W) begin : g_err_fit
      $error("configuration field exceeds register");
   end
   if (!(PA_MSB < PD_LSB || PD_MSB < PA_LSB)) begin : g_err_ovl
      $error("address and data fields overlap");
   end
   if ((STRB_BIT >= PA_LSB && STRB_BIT <= PA_MSB) ||
       (STRB_BIT >= PD_LSB && STRB_BIT <= PD_MSB) ||
       STRB_BIT >= HALF_W) begin : g_err_strb
      $error("strobe bit collides with a field");
   end
   if (CFG_OFS == LANE_OFS) begin : g_err_ofs
      $error("register offsets must differ");
   end
   if (CFG_OFS >= (1 << ADDR_W) || LANE_OFS >= (1 << ADDR_W)) begin : g_err_afit
      $error("offset does not fit address width");
   end

   rsel_e sel;
   half_t cfg_q;
   half_t lane_q;
   half_t wr_val;
   half_t wr_msk;
   logic  cfg_we;
   logic  lane_we;

   assign wr_val = bus_wdata[HALF_W-1:0];
   assign wr_msk = bus_wdata[WORD_W-1:HALF_W];

   always_comb begin
      if (bus_addr == CFG_A) begin
         sel = RSEL_CFG;
      end else if (bus_addr == LANE_A) begin
         sel = RSEL_LANE;
      end else begin
         sel = RSEL_NONE;
      end
   end

   assign cfg_we  = bus_wen && (sel == RSEL_CFG);
   assign lane_we = bus_wen && (sel == RSEL_LANE);

   hwm_masked_half #(.W(HALF_W)) u_cfg_reg (
      .clk (clk),
      .rst (rst),
      .we  (cfg_we),
      .val (wr_val),
      .msk (wr_msk),
      .q   (cfg_q)
   );

   hwm_masked_half #(.W(HALF_W)) u_lane_reg (
      .clk (clk),
      .rst (rst),
      .we  (lane_we),
      .val (wr_val),
      .msk (wr_msk),
      .q   (lane_q)
   );

   hwm_cfg_port #(.PA_W(PA_W), .PD_W(PD_W)) u_cfg_port (
      .clk       (clk),
      .rst       (rst),
      .strb_q    (cfg_q[STRB_BIT]),
      .fld_addr  (cfg_q[PA_MSB:PA_LSB]),
      .fld_data  (cfg_q[PD_MSB:PD_LSB]),
      .txn_valid (phy_cfg_valid),
      .txn_addr  (phy_cfg_addr),
      .txn_data  (phy_cfg_data)
   );

   hwm_lane_idle #(.LANES(LANES)) u_lane_map (
      .idle_bits (lane_q[IDLE_LSB +: LANES]),
      .lane_idle (lane_idle)
   );

   // the mask half is never stored, so the upper read half is zero
   always_comb begin
      bus_rdata = '0;
      case (sel)
         RSEL_CFG:  bus_rdata[HALF_W-1:0] = cfg_q;
         RSEL_LANE: bus_rdata[HALF_W-1:0] = lane_q;
         default:   bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/hwmask_ctrl_regs_chk.sv
module hwmask_ctrl_regs_chk #(
   parameter int ADDR_W   = 8,
   parameter int CFG_OFS  = 0,
   parameter int LANE_OFS = 4,
   parameter int LANES    = 4,
   parameter int PA_W     = 6,
   parameter int PD_W     = 4
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wen,
   input logic              w_strb_v,
   input logic              w_strb_m,
   input logic              w_idle0_v,
   input logic              w_idle0_m,
   input logic              w_hi_zero,
   input logic [15:0]       rd_hi,
   input logic              phy_cfg_valid,
   input logic [PA_W-1:0]   phy_cfg_addr,
   input logic [PD_W-1:0]   phy_cfg_data,
   input logic [LANES-1:0]  lane_idle
);
   localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_OFS);
   localparam logic [ADDR_W-1:0] LANE_A = ADDR_W'(LANE_OFS);

   logic cfg_wr;
   logic lane_wr;
   assign cfg_wr  = bus_wen && (bus_addr == CFG_A);
   assign lane_wr = bus_wen && (bus_addr == LANE_A);

   // R1: an unmasked idle bit keeps its value
   p_mask_keep_r1: assert property (@(posedge clk) disable iff (rst)
      (lane_wr && !w_idle0_m) |=> $stable(lane_idle[0]));

   // R1: a write word with an all-zero mask half changes no lane output
   p_zero_mask_r1: assert property (@(posedge clk) disable iff (rst)
      (lane_wr && w_hi_zero) |=> $stable(lane_idle));

   // R2: upper read half is always zero
   p_hi_zero_r2: assert property (@(posedge clk) disable iff (rst)
      rd_hi == 16'h0);

   // R3: reset clears the outputs
   p_reset_clear_r3: assert property (@(posedge clk)
      rst |=> (!phy_cfg_valid && lane_idle == '0 &&
               phy_cfg_addr == '0 && phy_cfg_data == '0));

   // R4: transaction fields only move together with a pulse
   p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !phy_cfg_valid |-> ($stable(phy_cfg_addr) && $stable(phy_cfg_data)));

   // R5: a pulse lasts one cycle
   p_pulse_single_r5: assert property (@(posedge clk) disable iff (rst)
      phy_cfg_valid |=> !phy_cfg_valid);

   // R5: a pulse traces back to a masked strobe-set write two edges earlier
   p_pulse_cause_r5: assert property (@(posedge clk) disable iff (rst)
      phy_cfg_valid |-> $past(cfg_wr && w_strb_m && w_strb_v, 2));

   // R6: an unmasked strobe cannot start a transaction
   p_strb_masked_r6: assert property (@(posedge clk) disable iff (rst)
      (cfg_wr && !w_strb_m) |-> ##2 !phy_cfg_valid);

   // R7: a masked idle write lands on the lane output
   p_lane_write_r7: assert property (@(posedge clk) disable iff (rst)
      (lane_wr && w_idle0_m) |=> (lane_idle[0] == $past(w_idle0_v)));

   // R8: no write, no lane change
   p_no_write_r8: assert property (@(posedge clk) disable iff (rst)
      !bus_wen |=> $stable(lane_idle));
endmodule

bind hwmask_ctrl_regs hwmask_ctrl_regs_chk #(
   .ADDR_W   (ADDR_W),
   .CFG_OFS  (CFG_OFS),
   .LANE_OFS (LANE_OFS),
   .LANES    (LANES),
   .PA_W     (PA_W),
   .PD_W     (PD_W)
) u_chk (
   .clk           (clk),
   .rst           (rst),
   .bus_addr      (bus_addr),
   .bus_wen       (bus_wen),
   .w_strb_v      (bus_wdata[STRB_BIT]),
   .w_strb_m      (bus_wdata[16 + STRB_BIT]),
   .w_idle0_v     (bus_wdata[IDLE_LSB]),
   .w_idle0_m     (bus_wdata[16 + IDLE_LSB]),
   .w_hi_zero     (bus_wdata[31:16] == 16'h0),
   .rd_hi         (bus_rdata[31:16]),
   .phy_cfg_valid (phy_cfg_valid),
   .phy_cfg_addr  (phy_cfg_addr),
   .phy_cfg_data  (phy_cfg_data),
   .lane_idle     (lane_idle)
);

// File: tb/hwmask_ctrl_regs_test.sv
`timescale 1ns/1ps
module hwmask_ctrl_regs_test;
   localparam logic [7:0] A_CFG  = 8'h00;
   localparam logic [7:0] A_LANE = 8'h04;
   localparam logic [7:0] A_NONE = 8'h10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  bus_addr = 8'h0;
   logic [31:0] bus_wdata = 32'h0;
   logic        bus_wen = 1'b0;
   logic [31:0] bus_rdata;
   logic        phy_cfg_valid;
   logic [5:0]  phy_cfg_addr;
   logic [3:0]  phy_cfg_data;
   logic [3:0]  lane_idle;

   int n_chk = 0;
   int n_bad = 0;

   logic [15:0] cfg_m = 16'h0;
   logic [15:0] lane_m = 16'h0;
   logic [5:0]  exp_a = 6'h0;
   logic [3:0]  exp_d = 4'h0;

   always #2 clk = ~clk;

   hwmask_ctrl_regs uut (
      .clk (clk), .rst (rst),
      .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_wen (bus_wen),
      .bus_rdata (bus_rdata),
      .phy_cfg_valid (phy_cfg_valid), .phy_cfg_addr (phy_cfg_addr),
      .phy_cfg_data (phy_cfg_data), .lane_idle (lane_idle)
   );

   function automatic logic [15:0] merge(input logic [15:0] old, input logic [31:0] w);
      return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
   endfunction

   function automatic logic [31:0] read_model(input logic [7:0] a);
      if (a == A_CFG)  return {16'h0, cfg_m};
      if (a == A_LANE) return {16'h0, lane_m};
      return 32'h0;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all(input logic exp_pulse, input string tag);
      chk({"R5/R6 pulse ", tag}, {31'h0, phy_cfg_valid}, {31'h0, exp_pulse});
      chk({"R4 addr ", tag}, {26'h0, phy_cfg_addr}, {26'h0, exp_a});
      chk({"R4 data ", tag}, {28'h0, phy_cfg_data}, {28'h0, exp_d});
      chk({"R7 lanes ", tag}, {28'h0, lane_idle}, {28'h0, lane_m[6:3]});
      bus_addr = A_CFG;
      #0.5;
      chk({"R9 cfg readback ", tag}, bus_rdata, read_model(A_CFG));
      bus_addr = A_LANE;
      #0.5;
      chk({"R9 lane readback ", tag}, bus_rdata, read_model(A_LANE));
   endtask

   // one write, then readback next cycle and port check after the following edge
   task automatic do_wr(input logic [7:0] a, input logic [31:0] d, input string tag);
      logic old_s;
      logic rise;
      old_s = cfg_m[0];
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wen   = 1'b1;
      @(posedge clk);
      if (a == A_CFG) cfg_m = merge(cfg_m, d);
      else if (a == A_LANE) lane_m = merge(lane_m, d);
      rise = !old_s && cfg_m[0];
      if (rise) begin
         exp_a = cfg_m[6:1];
         exp_d = cfg_m[10:7];
      end
      @(negedge clk);
      bus_wen = 1'b0;
      #0.5;
      chk({"R1/R2/R8 readback ", tag}, bus_rdata, read_model(a));
      chk({"R2 upper half ", tag}, {16'h0, bus_rdata[31:16]}, 32'h0);
      chk({"R5 no early pulse ", tag}, {31'h0, phy_cfg_valid}, 32'h0);
      @(posedge clk);
      @(negedge clk);
      check_all(rise, tag);
   endtask

   // cycle with bus_wen low but live address and data
   task automatic idle_poke(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wen   = 1'b0;
      @(posedge clk);
      @(negedge clk);
      #0.5;
      chk("R8 wen low readback", bus_rdata, read_model(a));
      @(posedge clk);
      @(negedge clk);
      check_all(1'b0, "R8 wen low");
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd20240611);
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R3: state after reset
      #0.5;
      chk("R3 valid after reset", {31'h0, phy_cfg_valid}, 32'h0);
      chk("R3 addr after reset", {26'h0, phy_cfg_addr}, 32'h0);
      chk("R3 data after reset", {28'h0, phy_cfg_data}, 32'h0);
      check_all(1'b0, "R3 reset");

      // three-step configuration access: fields, strobe set, strobe clear
      do_wr(A_CFG, {16'h07FE, 16'h052A}, "seq fields");
      do_wr(A_CFG, {16'h0001, 16'h0001}, "seq strobe set");
      do_wr(A_CFG, {16'h0001, 16'h0000}, "seq strobe clear");
      // R6: strobe value 1 with its mask bit 16 clear
      do_wr(A_CFG, {16'h07FE, 16'h07FF}, "R6 unmasked strobe");
      // fields and strobe together in one write
      do_wr(A_CFG, {16'h07FF, 16'h0393}, "combined write");
      // R6: strobe already 1
      do_wr(A_CFG, {16'h07FF, 16'h0461}, "R6 strobe held");
      do_wr(A_CFG, {16'h0001, 16'h0000}, "R6 strobe clear");
      // R1: mask-only on data field keeps the address field
      do_wr(A_CFG, {16'h0780, 16'hFFFF}, "R1 partial mask");
      do_wr(A_CFG, {16'h0001, 16'h0001}, "R4 capture partial");
      do_wr(A_CFG, {16'h0001, 16'h0000}, "clear");

      // R7: each lane into and out of idle
      for (int n = 0; n < 4; n++) begin
         do_wr(A_LANE, {16'h0001 << (3 + n), 16'hFFFF}, "R7 lane idle on");
      end
      do_wr(A_LANE, {16'h0028, 16'h0000}, "R7 lanes 0,2 off");
      do_wr(A_LANE, {16'h0000, 16'h0000}, "R1 zero mask");
      // R8: unmapped writes and wen low
      do_wr(A_NONE, 32'hFFFF_FFFF, "R8 unmapped");
      idle_poke(A_CFG, 32'hFFFF_FFFF);
      idle_poke(A_LANE, 32'hFFFF_0000);

      // constrained random mix
      for (int i = 0; i < 400; i++) begin
         logic [7:0]  a;
         logic [31:0] d;
         int unsigned pick;
         pick = $urandom % 5;
         a = (pick < 2) ? A_CFG : (pick < 4) ? A_LANE : A_NONE;
         d = $urandom;
         if (($urandom % 3) == 0) d[16] = 1'b1;
         do_wr(a, d, "random");
      end
      if (seed == 32'h0) $display("seed word zero");
      finish_run();
   end
endmodule